// File: doc/BRIEF.md
# Banked Extended RAM Access Port

This block is the byte-wide host register file of a multiplexed-bus clock device, reduced to its memory-access side. A host bus with an 8-bit address and 8-bit data reaches general-purpose RAM, a small bank of identity bytes and a larger battery-backed RAM. The larger RAM is not mapped directly. It is reached through an indirect window: a pointer register pair and a data port.

One bit in the first control register picks which of two banks is decoded in the upper address range. Bank zero shows 64 more general RAM bytes there. Bank one shows the identity bytes, two extended control registers, the pointer pair and the data port. When the burst-enable bit is set, each complete access through the data port moves the pointer on by one byte. A host can then stream a block in or out without rewriting the pointer. Timekeeping, power switching and battery handling are not part of this block, and the remaining clock and control addresses read as zero.

An access is one strobe pulse of any length on `host_sel`. A write is stored on the first clock edge of the strobe. Read data follows the address combinationally. A burst step is taken on the edge that ends the strobe.

Top module: `xram_bank_port`

## Requirements
- R1: After reset, the control byte at 0x0A, extended control bytes 0x4A and 0x4B, and the extended RAM pointer all read 0, so bank zero is selected and burst mode is off.
- R2: Bit 4 of the byte at 0x0A selects the bank. With it at 0, addresses 0x40 to 0x7F are 64 bytes of read/write RAM that bank one does not disturb.
- R3: Addresses 0x0E to 0x3F are 50 bytes of read/write RAM that are shared by both banks.
- R4: In bank one, 0x40 reads the MODEL_ID parameter, and 0x41 to 0x46 read the SERIAL_ID parameter one byte at a time, least significant byte first. 0x47 reads a CRC-8 (reflected polynomial 0x8C, initial value 0, each byte fed least significant bit first) taken over bytes 0x40 to 0x46 in address order. Writes to 0x40 to 0x47 have no effect.
- R5: In bank one, 0x50 is the low byte and 0x51 the high byte of the extended RAM pointer. Pointer bits at or above log2(XRAM_BYTES) read 0.
- R6: In bank one, a write to 0x53 stores the data byte at the pointer location, and a read of 0x53 returns the byte at that location.
- R7: With bit 5 of 0x4A set, every read or write strobe to 0x53 advances the pointer by one when the strobe ends.
- R8: With bit 5 of 0x4A clear, data-port accesses leave the pointer unchanged.
- R9: A burst increment from the last byte (XRAM_BYTES-1) wraps the pointer to 0.
- R10: A data-port strobe held for several clocks causes exactly one write and at most one pointer increment.
- R11: 0x4A and 0x4B are read/write registers only in bank one. In bank zero, the same addresses are general RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Access strobe; one pulse is one access |
| host_we | input | 1 | 1 = write, 0 = read, held with the strobe |
| host_addr | input | 8 | Register address, held with the strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |

## Verification
The bound checker tests the pointer on every cycle. It must step by exactly one after a data-port strobe ends with burst on. It must stay put after such a strobe with burst off, and stay put while any strobe is held. The checker also tests that the model byte appears whenever bank one is decoded at 0x40. Memory contents cannot be covered by these properties, and neither can the wrap at the end of the RAM, the shared window across banks, the check byte, or the bank-zero aliasing of 0x4A. Those are shown only by the bench's scenarios. The bench fills the whole extended RAM in burst mode with strobes of mixed length and reads it back, and it sweeps every general RAM byte in both banks.

// File: rtl/xram_bank_port.sv
module xram_bank_port #(
  parameter int          XRAM_BYTES = 2048,
  parameter logic [7:0]  MODEL_ID   = 8'h72,
  parameter logic [47:0] SERIAL_ID  = 48'h0000_5A3C_9E11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sel,
  input  logic       host_we,
  input  logic [7:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  localparam int AW = $clog2(XRAM_BYTES);

  function automatic logic [7:0] id_crc(input logic [55:0] bytes);
    logic [7:0] c;
    logic [7:0] b;
    c = 8'h00;
    for (int k = 0; k < 7; k++) begin
      b = bytes[8*k +: 8];
      for (int j = 0; j < 8; j++) begin
        if (c[0] ^ b[0]) c = (c >> 1) ^ 8'h8C;
        else             c = c >> 1;
        b = b >> 1;
      end
    end
    return c;
  endfunction

  localparam logic [7:0] ID_CHK = id_crc({SERIAL_ID, MODEL_ID});

  logic [7:0]    ctrl_a, xctl_a, xctl_b;
  logic [AW-1:0] ptr;
  logic          sel_q, dp_q;
  logic [7:0]    gram [50];
  logic [7:0]    bram [64];
  logic [7:0]    xram [XRAM_BYTES];

  logic        bank1, burst_en, rise, fall, wr;
  logic [15:0] ptr16;
  logic [5:0]  gidx;
  logic        in_gram, in_upper;

  assign bank1    = ctrl_a[4];
  assign burst_en = xctl_a[5];
  assign rise     = host_sel & ~sel_q;
  assign fall     = sel_q & ~host_sel;
  assign wr       = rise & host_we;
  assign ptr16    = 16'(ptr);
  assign gidx     = 6'(host_addr - 8'd14);
  assign in_gram  = (host_addr >= 8'h0E) && (host_addr <= 8'h3F);
  assign in_upper = (host_addr >= 8'h40) && (host_addr <= 8'h7F);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_a <= 8'h00;
      xctl_a <= 8'h00;
      xctl_b <= 8'h00;
      ptr    <= '0;
      sel_q  <= 1'b0;
      dp_q   <= 1'b0;
    end else begin
      sel_q <= host_sel;
      if (rise) dp_q <= bank1 && (host_addr == 8'h53);
      if (wr && host_addr == 8'h0A) ctrl_a <= host_wdata;
      if (wr && bank1 && host_addr == 8'h4A) xctl_a <= host_wdata;
      if (wr && bank1 && host_addr == 8'h4B) xctl_b <= host_wdata;
      if (wr && bank1 && host_addr == 8'h50)
        ptr <= AW'({ptr16[15:8], host_wdata});
      else if (wr && bank1 && host_addr == 8'h51)
        ptr <= AW'({host_wdata, ptr16[7:0]});
      else if (fall && dp_q && burst_en)
        ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && in_gram) gram[gidx] <= host_wdata;
    if (wr && in_upper && !bank1) bram[host_addr[5:0]] <= host_wdata;
    if (wr && bank1 && host_addr == 8'h53) xram[ptr] <= host_wdata;
  end

  always_comb begin
    host_rdata = 8'h00;
    if (host_addr == 8'h0A) host_rdata = ctrl_a;
    else if (in_gram) host_rdata = gram[gidx];
    else if (in_upper && !bank1) host_rdata = bram[host_addr[5:0]];
    else if (in_upper) begin
      case (host_addr)
        8'h40: host_rdata = MODEL_ID;
        8'h41: host_rdata = SERIAL_ID[7:0];
        8'h42: host_rdata = SERIAL_ID[15:8];
        8'h43: host_rdata = SERIAL_ID[23:16];
        8'h44: host_rdata = SERIAL_ID[31:24];
        8'h45: host_rdata = SERIAL_ID[39:32];
        8'h46: host_rdata = SERIAL_ID[47:40];
        8'h47: host_rdata = ID_CHK;
        8'h4A: host_rdata = xctl_a;
        8'h4B: host_rdata = xctl_b;
        8'h50: host_rdata = ptr16[7:0];
        8'h51: host_rdata = ptr16[15:8];
        8'h53: host_rdata = xram[ptr];
        default: host_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/xram_bank_port_chk.sv
module xram_bank_port_chk #(
  parameter int         AW       = 11,
  parameter logic [7:0] MODEL_ID = 8'h72
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_sel,
  input logic [7:0]    host_addr,
  input logic [7:0]    host_rdata,
  input logic          bank1,
  input logic          burst_en,
  input logic [AW-1:0] ptr
);
  logic s_q, d_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_q <= 1'b0;
      d_q <= 1'b0;
    end else begin
      s_q <= host_sel;
      if (host_sel && !s_q) d_q <= bank1 && (host_addr == 8'h53);
    end
  end

  a_r7_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (s_q && !host_sel && d_q && burst_en) |=> (ptr == $past(ptr) + 1'b1));

  a_r8_no_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (s_q && !host_sel && !burst_en) |=> $stable(ptr));

  a_r10_held_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (s_q && host_sel) |=> $stable(ptr));

  a_r4_model_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (bank1 && host_addr == 8'h40) |-> (host_rdata == MODEL_ID));
endmodule

bind xram_bank_port xram_bank_port_chk #(.AW(AW), .MODEL_ID(MODEL_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_addr(host_addr),
  .host_rdata(host_rdata), .bank1(bank1), .burst_en(burst_en), .ptr(ptr)
);

// File: tb/xram_bank_port_bench.sv
module xram_bank_port_bench;
  localparam int          XB    = 128;
  localparam logic [7:0]  MID   = 8'h71;
  localparam logic [47:0] SER   = 48'hC3A5_0F12_8E47;

  logic clk = 0, rst_n = 0, sel = 0, we = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xram_bank_port #(.XRAM_BYTES(XB), .MODEL_ID(MID), .SERIAL_ID(SER)) u_xram_bank_port (
    .clk(clk), .rst_n(rst_n), .host_sel(sel), .host_we(we),
    .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata));

  function automatic logic [7:0] ref_chk();
    logic [7:0] acc = 0;
    logic [7:0] by;
    for (int n = 0; n < 7; n++) begin
      by = (n == 0) ? MID : SER[8*(n-1) +: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = acc[0] ^ by[j];
        acc = {1'b0, acc[7:1]};
        if (fb) acc = acc ^ 8'h8C;
      end
    end
    return acc;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input int len = 1);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    repeat (len) @(negedge clk);
    sel = 0; we = 0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, input int len = 1);
    @(negedge clk); sel = 1; we = 0; addr = a;
    #5 d = rdata;
    repeat (len) @(negedge clk);
    sel = 0;
    @(negedge clk);
  endtask

  task automatic rdc(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rdc("R1", 8'h0A, 8'h00);
    wr(8'h0A, 8'h10);
    rdc("R1", 8'h4A, 8'h00);
    rdc("R1", 8'h4B, 8'h00);
    rdc("R1", 8'h50, 8'h00);
    rdc("R1", 8'h51, 8'h00);
    wr(8'h0A, 8'h00);

    for (int a = 8'h40; a <= 8'h7F; a++) wr(8'(a), 8'(a) ^ 8'hA5);
    for (int a = 8'h0E; a <= 8'h3F; a++) wr(8'(a), 8'(a * 3));
    wr(8'h0A, 8'h10);
    for (int a = 8'h0E; a <= 8'h3F; a++) rdc("R3", 8'(a), 8'(a * 3));
    for (int a = 8'h0E; a <= 8'h3F; a++) wr(8'(a), ~8'(a));
    rdc("R11", 8'h4A, 8'h00);
    wr(8'h4B, 8'h5E);
    rdc("R11", 8'h4B, 8'h5E);
    wr(8'h41, 8'hFF);
    rdc("R4", 8'h40, MID);
    for (int k = 0; k < 6; k++) rdc("R4", 8'(8'h41 + k), SER[8*k +: 8]);
    rdc("R4", 8'h47, ref_chk());
    wr(8'h0A, 8'h00);
    for (int a = 8'h0E; a <= 8'h3F; a++) rdc("R3", 8'(a), ~8'(a));
    for (int a = 8'h40; a <= 8'h7F; a++) rdc("R2", 8'(a), 8'(a) ^ 8'hA5);
    rdc("R11", 8'h4A, 8'h4A ^ 8'hA5);

    wr(8'h0A, 8'h10);
    wr(8'h50, 8'hFF);
    wr(8'h51, 8'h12);
    rdc("R5", 8'h50, 8'h7F);
    rdc("R5", 8'h51, 8'h00);

    wr(8'h50, 8'h05);
    wr(8'h53, 8'hC7);
    rdc("R8", 8'h50, 8'h05);
    rdc("R6", 8'h53, 8'hC7);
    rdc("R8", 8'h50, 8'h05);

    wr(8'h4A, 8'h20);
    rdc("R7", 8'h4A, 8'h20);
    wr(8'h50, 8'h00);
    for (int i = 0; i < XB; i++) wr(8'h53, 8'(i * 7 + 3), 1 + (i % 3));
    rdc("R9", 8'h50, 8'h00);
    for (int i = 0; i < XB; i++) begin
      rd(8'h53, v, 1 + (i % 2) * 2);
      check("R7", v, 8'(i * 7 + 3));
    end
    rdc("R10", 8'h50, 8'h00);
    wr(8'h50, 8'h7F);
    wr(8'h53, 8'h99, 3);
    rdc("R9", 8'h50, 8'h00);
    rd(8'h53, v, 4);
    rdc("R10", 8'h50, 8'h01);
    check("R10", v, 8'(0 * 7 + 3));

    wr(8'h4A, 8'h00);
    wr(8'h50, 8'h0A);
    for (int k = 0; k < 3; k++) rdc("R8", 8'h53, 8'(10 * 7 + 3));
    rdc("R8", 8'h50, 8'h0A);
    wr(8'h50, 8'h7F);
    rdc("R6", 8'h53, 8'h99);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule